// File: doc/BRIEF.md
# Direct-Page Indexed-Indirect Pointer Fetch Unit

This unit resolves the pointer location for the X-indexed, direct-page indirect addressing mode of an 8/16-bit processor, then fetches the two pointer bytes from memory. When the control path starts it, the unit adds three values: the 16-bit direct-page base, the index and the 8-bit operand byte. From that sum it forms the bank-zero address of the pointer's low byte and the address of its high byte. It also reports whether the instruction keeps one extra internal cycle.

The unit wraps the result inside a single page only under two conditions together: the processor runs in emulation mode, and the base register's low byte is zero. In every other case it uses the full 16-bit sum. It then reads the low byte and the high byte over a request/response port that holds each request until the response arrives. The unit ends with a single-cycle done pulse that carries the assembled 16-bit pointer. Final operand fetch and data-bank combination are left to the surrounding datapath.

Top module: `dpx_ptr_fetch`

## Requirements
- R1: While reset is active and after its release, `mem_req_o`, `done_o` and `busy_o` are 0 and `ptr_o` is 0x0000.
- R2: When `emu_i`=1 and `dbase_i[7:0]`=0, the low-byte address is {`dbase_i[15:8]`, (effective X[7:0] + `opnd_i`) mod 256}.
- R3: When `dbase_i[7:0]`≠0, the low-byte address is (`dbase_i` + effective X + `opnd_i`) mod 65536, in either mode.
- R4: When `emu_i`=0 and `dbase_i[7:0]`=0, the low-byte address is the full 16-bit sum, with no page wrap.
- R5: When `xwide_i`=0, `xidx_i[15:8]` is ignored and the effective X is {8'h00, `xidx_i[7:0]`}. When `xwide_i`=1, the effective X is all 16 bits.
- R6: In the page-wrap case of R2, the high-byte address keeps the same upper byte and has low byte (lo[7:0]+1) mod 256. In every other case, it is (lo+1) mod 65536, so 0xFFFF is followed by 0x0000.
- R7: `extra_o` is 1 exactly when `dbase_i[7:0]`≠0. The first memory request appears in the cycle after the start edge when `extra_o` is 0, and one cycle later when `extra_o` is 1.
- R8: The low byte is read first and the high byte second. Each request holds `mem_req_o` high with a stable `mem_addr_o` until `mem_rvalid_i` is seen.
- R9: `done_o` is a one-cycle pulse in the cycle after the high-byte response. At that time `ptr_o` is {high byte, low byte}, and `ptr_o` holds until the next completion.
- R10: A `start_i` raised while `busy_o`=1 is ignored. The addresses, the memory sequence and the pointer of the running fetch are unchanged.
- R11: `lo_addr_o`, `hi_addr_o` and `extra_o` are registered at the accepted start edge and are valid from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a pointer fetch (accepted only when idle) |
| dbase_i | input | 16 | Direct-page base register |
| xidx_i | input | 16 | Index register value |
| xwide_i | input | 1 | 1 = 16-bit index, 0 = 8-bit index |
| opnd_i | input | 8 | Operand byte |
| emu_i | input | 1 | Emulation mode active |
| lo_addr_o | output | 16 | Address of the pointer low byte |
| hi_addr_o | output | 16 | Address of the pointer high byte |
| extra_o | output | 1 | Extra internal cycle kept |
| busy_o | output | 1 | Fetch in progress |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address (bank zero) |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 8 | Read response data |
| done_o | output | 1 | One-cycle completion pulse |
| ptr_o | output | 16 | Assembled pointer |

## Verification
The address outputs and `extra_o` are due one cycle after the start edge. The bench samples them at the first falling edge after that edge. It counts falling edges until the first request and expects one or two, depending on the extra-cycle flag. The memory model answers each request after a random latency of zero to two cycles. The bench then expects `done_o` in the cycle that follows the second response, and checks that `done_o` is low again one cycle later. The bench records every address the model answers, so the order and values of the two reads are checked against the bench's own address functions.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int PAGE_W = ADDR_W - BYTE_W;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_GAP  = 2'd1,
    SQ_RDLO = 2'd2,
    SQ_RDHI = 2'd3
  } sq_state_e;
endpackage

// File: rtl/dpx_addr_calc.sv
module dpx_addr_calc
  import dpx_pkg::*;
(
  input  logic [ADDR_W-1:0] dbase_i,
  input  logic [ADDR_W-1:0] xidx_i,
  input  logic              xwide_i,
  input  logic [BYTE_W-1:0] opnd_i,
  input  logic              emu_i,
  output logic [ADDR_W-1:0] lo_addr_o,
  output logic [ADDR_W-1:0] hi_addr_o,
  output logic              extra_o,
  output logic              wrap_o
);
  logic [ADDR_W-1:0] x_eff;
  logic [ADDR_W-1:0] full_sum;
  logic [BYTE_W-1:0] page_off;
  logic              dl_zero;

  always_comb begin
    x_eff    = xwide_i ? xidx_i : {{PAGE_W{1'b0}}, xidx_i[BYTE_W-1:0]};
    full_sum = dbase_i + x_eff + {{PAGE_W{1'b0}}, opnd_i};
    page_off = x_eff[BYTE_W-1:0] + opnd_i;
    dl_zero  = (dbase_i[BYTE_W-1:0] == '0);
    wrap_o   = emu_i & dl_zero;
    extra_o  = ~dl_zero;
    if (wrap_o) begin
      lo_addr_o = {dbase_i[ADDR_W-1:BYTE_W], page_off};
      hi_addr_o = {dbase_i[ADDR_W-1:BYTE_W], page_off + {{(BYTE_W-1){1'b0}}, 1'b1}};
    end else begin
      lo_addr_o = full_sum;
      hi_addr_o = full_sum + {{(ADDR_W-1){1'b0}}, 1'b1};
    end
  end
endmodule

// File: rtl/dpx_fetch_seq.sv
module dpx_fetch_seq
  import dpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] calc_lo_i,
  input  logic [ADDR_W-1:0] calc_hi_i,
  input  logic              calc_extra_i,
  output logic [ADDR_W-1:0] lo_addr_o,
  output logic [ADDR_W-1:0] hi_addr_o,
  output logic              extra_o,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] ptr_o
);
  sq_state_e         st_q, st_d;
  logic [ADDR_W-1:0] lo_q, hi_q, ptr_q;
  logic [BYTE_W-1:0] lob_q;
  logic              extra_q, done_q, done_d;
  logic              load_en, lob_en, ptr_en;

  always_comb begin
    st_d    = st_q;
    load_en = 1'b0;
    lob_en  = 1'b0;
    ptr_en  = 1'b0;
    done_d  = 1'b0;
    unique case (st_q)
      SQ_IDLE: if (start_i) begin
        load_en = 1'b1;
        st_d    = calc_extra_i ? SQ_GAP : SQ_RDLO;
      end
      SQ_GAP:  st_d = SQ_RDLO;
      SQ_RDLO: if (mem_rvalid_i) begin
        lob_en = 1'b1;
        st_d   = SQ_RDHI;
      end
      SQ_RDHI: if (mem_rvalid_i) begin
        ptr_en = 1'b1;
        done_d = 1'b1;
        st_d   = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      lo_q    <= '0;
      hi_q    <= '0;
      extra_q <= 1'b0;
      lob_q   <= '0;
      ptr_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (load_en) begin
        lo_q    <= calc_lo_i;
        hi_q    <= calc_hi_i;
        extra_q <= calc_extra_i;
      end
      if (lob_en) lob_q <= mem_rdata_i;
      if (ptr_en) ptr_q <= {mem_rdata_i, lob_q};
    end
  end

  assign lo_addr_o  = lo_q;
  assign hi_addr_o  = hi_q;
  assign extra_o    = extra_q;
  assign busy_o     = (st_q != SQ_IDLE);
  assign mem_req_o  = (st_q == SQ_RDLO) || (st_q == SQ_RDHI);
  assign mem_addr_o = (st_q == SQ_RDHI) ? hi_q : lo_q;
  assign done_o     = done_q;
  assign ptr_o      = ptr_q;

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o)));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(mem_req_o && mem_rvalid_i));
  p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && calc_extra_i) |=> (busy_o && !mem_req_o));
  p_nogap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && !calc_extra_i) |=> mem_req_o);
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(lo_addr_o) && $stable(hi_addr_o)));
endmodule

// File: rtl/dpx_ptr_fetch.sv
module dpx_ptr_fetch
  import dpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] dbase_i,
  input  logic [ADDR_W-1:0] xidx_i,
  input  logic              xwide_i,
  input  logic [BYTE_W-1:0] opnd_i,
  input  logic              emu_i,
  output logic [ADDR_W-1:0] lo_addr_o,
  output logic [ADDR_W-1:0] hi_addr_o,
  output logic              extra_o,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [ADDR_W-1:0] c_lo, c_hi;
  logic              c_extra, c_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dpx_addr_calc u_calc (
    .dbase_i  (dbase_i),
    .xidx_i   (xidx_i),
    .xwide_i  (xwide_i),
    .opnd_i   (opnd_i),
    .emu_i    (emu_i),
    .lo_addr_o(c_lo),
    .hi_addr_o(c_hi),
    .extra_o  (c_extra),
    .wrap_o   (c_wrap)
  );

  dpx_fetch_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (start_i),
    .calc_lo_i   (c_lo),
    .calc_hi_i   (c_hi),
    .calc_extra_i(c_extra),
    .lo_addr_o   (lo_addr_o),
    .hi_addr_o   (hi_addr_o),
    .extra_o     (extra_o),
    .busy_o      (busy_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i),
    .mem_rdata_i (mem_rdata_i),
    .done_o      (done_o),
    .ptr_o       (ptr_o)
  );

  p_same_page_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    c_wrap |-> (c_hi[ADDR_W-1:BYTE_W] == c_lo[ADDR_W-1:BYTE_W]));
  p_base_page_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    c_wrap |-> (c_lo[ADDR_W-1:BYTE_W] == dbase_i[ADDR_W-1:BYTE_W]));
endmodule

// File: tb/dpx_ptr_fetch_tb_top.sv
module dpx_ptr_fetch_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [15:0] dbase_i, xidx_i;
  logic        xwide_i, emu_i;
  logic [7:0]  opnd_i;
  logic [15:0] lo_addr_o, hi_addr_o, mem_addr_o, ptr_o;
  logic        extra_o, busy_o, mem_req_o, done_o;
  logic        mem_rvalid_i;
  logic [7:0]  mem_rdata_i;

  int checks = 0;
  int errors = 0;

  int          beats;
  logic [15:0] seen0, seen1;
  int          wcnt, lat;

  always #5 clk = ~clk;

  dpx_ptr_fetch dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dbase_i(dbase_i),
    .xidx_i(xidx_i), .xwide_i(xwide_i), .opnd_i(opnd_i), .emu_i(emu_i),
    .lo_addr_o(lo_addr_o), .hi_addr_o(hi_addr_o), .extra_o(extra_o),
    .busy_o(busy_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .done_o(done_o), .ptr_o(ptr_o)
  );

  function automatic logic [7:0] memf(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  function automatic logic [15:0] xeff(input logic [15:0] x, input logic xw);
    return xw ? x : {8'h00, x[7:0]};
  endfunction

  function automatic logic [15:0] e_lo(input logic [15:0] d, input logic [15:0] x,
                                       input logic xw, input logic [7:0] op, input logic em);
    logic [15:0] xe;
    logic [7:0]  off;
    xe  = xeff(x, xw);
    off = xe[7:0] + op;
    if (em && d[7:0] == 8'h00) return {d[15:8], off};
    return d + xe + {8'h00, op};
  endfunction

  function automatic logic [15:0] e_hi(input logic [15:0] lo, input logic [15:0] d, input logic em);
    if (em && d[7:0] == 8'h00) return {lo[15:8], lo[7:0] + 8'd1};
    return lo + 16'd1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory responder
  always @(negedge clk) begin
    mem_rvalid_i = 1'b0;
    if (rst_n && mem_req_o) begin
      if (wcnt >= lat) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = memf(mem_addr_o);
        if (beats == 0) seen0 = mem_addr_o;
        else if (beats == 1) seen1 = mem_addr_o;
        beats++;
        wcnt = 0;
        lat  = $urandom % 3;
      end else begin
        wcnt++;
      end
    end
  end

  task automatic run_one(input logic [15:0] d, input logic [15:0] x, input logic xw,
                         input logic [7:0] op, input logic em, input bit inject, input string tag);
    logic [15:0] elo, ehi;
    logic        eex;
    int          n;
    elo = e_lo(d, x, xw, op, em);
    ehi = e_hi(elo, d, em);
    eex = (d[7:0] != 8'h00);
    @(negedge clk);
    beats = 0; wcnt = 0;
    dbase_i = d; xidx_i = x; xwide_i = xw; opnd_i = op; emu_i = em; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R2 R3 R4 R5 R11: addresses registered one cycle after start
    chk({tag, " R11 lo_addr"}, {16'h0, lo_addr_o}, {16'h0, elo});
    chk({tag, " R6 hi_addr"}, {16'h0, hi_addr_o}, {16'h0, ehi});
    chk({tag, " R7 extra"}, {31'h0, extra_o}, {31'h0, eex});
    if (inject) begin
      start_i = 1'b1;
      dbase_i = ~d; xidx_i = ~x; opnd_i = ~op; emu_i = ~em;
    end
    n = 1;
    while (!mem_req_o && n < 10) begin
      @(negedge clk);
      start_i = 1'b0;
      n++;
    end
    start_i = 1'b0;
    chk({tag, " R7 first request cycle"}, n, eex ? 2 : 1);
    n = 0;
    while (!done_o && n < 30) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " R9 done seen"}, {31'h0, done_o}, 32'h1);
    chk({tag, " R8 read count"}, beats, 2);
    chk({tag, " R8 first read addr"}, {16'h0, seen0}, {16'h0, elo});
    chk({tag, " R8 second read addr"}, {16'h0, seen1}, {16'h0, ehi});
    chk({tag, " R9 ptr"}, {16'h0, ptr_o}, {16'h0, memf(ehi), memf(elo)});
    if (inject) chk({tag, " R10 lo_addr kept"}, {16'h0, lo_addr_o}, {16'h0, elo});
    @(negedge clk);
    chk({tag, " R9 done one cycle"}, {31'h0, done_o}, 32'h0);
    chk({tag, " R9 ptr held"}, {16'h0, ptr_o}, {16'h0, memf(ehi), memf(elo)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; start_i = 1'b0; dbase_i = '0; xidx_i = '0; xwide_i = 1'b0;
    opnd_i = '0; emu_i = 1'b0; mem_rvalid_i = 1'b0; mem_rdata_i = '0;
    beats = 0; wcnt = 0; lat = 0; seen0 = '0; seen1 = '0;
    repeat (4) @(negedge clk);
    chk("R1 req in reset", {31'h0, mem_req_o}, 32'h0);
    chk("R1 done in reset", {31'h0, done_o}, 32'h0);
    chk("R1 busy in reset", {31'h0, busy_o}, 32'h0);
    chk("R1 ptr in reset", {16'h0, ptr_o}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 busy after reset", {31'h0, busy_o}, 32'h0);
    chk("R1 req after reset", {31'h0, mem_req_o}, 32'h0);

    // R2: emulation, D low zero, page wrap of the low address
    run_one(16'h1200, 16'h00F0, 1'b0, 8'h20, 1'b1, 1'b0, "R2 wrap");
    // R6: emulation wrap, low byte 0xFF so high read wraps inside page
    run_one(16'h3400, 16'h0080, 1'b0, 8'h7F, 1'b1, 1'b0, "R6 page end");
    // R4: native, D low zero, no wrap
    run_one(16'h1200, 16'h00F0, 1'b0, 8'h20, 1'b0, 1'b0, "R4 native");
    // R3: emulation, D low non-zero, full sum
    run_one(16'h12F1, 16'h0010, 1'b0, 8'h05, 1'b1, 1'b0, "R3 emu dl");
    // R6: 16-bit wrap of the high address
    run_one(16'hFF01, 16'h00F0, 1'b0, 8'h0E, 1'b0, 1'b0, "R6 bank end");
    // R5: 8-bit index ignores upper X
    run_one(16'h0400, 16'hAB10, 1'b0, 8'h01, 1'b0, 1'b0, "R5 narrow");
    // R5: 16-bit index uses all of X
    run_one(16'h0400, 16'hAB10, 1'b1, 8'h01, 1'b0, 1'b0, "R5 wide");
    // R10: start while busy ignored
    run_one(16'h2203, 16'h0101, 1'b1, 8'h40, 1'b0, 1'b1, "R10 busy");
    run_one(16'h5600, 16'h00FF, 1'b0, 8'hFF, 1'b1, 1'b1, "R10 busy wrap");

    for (int i = 0; i < 150; i++) begin
      logic [15:0] d;
      d = $urandom;
      if ($urandom % 2) d[7:0] = 8'h00;
      run_one(d, 16'($urandom), 1'($urandom), 8'($urandom), 1'($urandom), ($urandom % 8) == 0, "R3 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule